// File: doc/BRIEF.md
# Register-Renaming Dispatch Stage

This block sits between decode and a set of execute units. Each decoded instruction arrives with a sequence number already attached. The block translates the two source register specifiers through a rename table and gives every architectural destination a fresh physical register taken from a free pool. It then hands the instruction to whichever execute unit can take it in that cycle. Because every write goes to a new physical register, two instructions that write the same architectural register never wait on each other.

A commit interface reports physical registers that are no longer needed. The block puts those registers back into the pool. The instruction leaves the block with the following fields:
- the physical destination,
- the architectural destination it renames, which commit uses to build an architecturally correct trace,
- the unchanged sequence number,
- the opcode payload.

The upstream side is a valid/ready stream. A transfer happens in a cycle where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold every `in_*` field steady. `in_ready` may depend on the presented payload, because only instructions that need a new register can be blocked by an empty pool. On the downstream side each execute unit has its own valid/ready pair. The payload outputs are shared by all units. Nothing is buffered inside the block: an instruction passes from input to a unit in the cycle it is accepted.

Top module: `rename_dispatch`

## Requirements
- R1: After reset, architectural register i (1..31) maps to physical register i, and the free pool holds exactly physical registers 32 to NUM_PHYS-1.
- R2: Source specifiers are translated through the table as it stood before this instruction's own destination update, so a source equal to the destination sees the older mapping. Architectural register 0 always reads as physical 0.
- R3: An accepted instruction with `in_has_dst`=1 and a nonzero destination receives the lowest-numbered free physical register. Later instructions read that register for this architectural register. Physical 0 is never handed out.
- R4: An instruction with `in_has_dst`=1 and destination 0, or with `in_has_dst`=0, gets `out_dst_phys`=0 and takes nothing from the pool.
- R5: The fields `out_seq`, `out_op`, `out_has_dst` and `out_dst_arch` equal the accepted instruction's `in_seq`, `in_op`, `in_has_dst` and `in_dst_arch`.
- R6: On acceptance, exactly one bit of `xu_valid` is high, and it belongs to a unit whose `xu_ready` is high. The search starts at a rotating pointer, which is 0 after reset and becomes k+1 (wrapping to 0) after a dispatch to unit k. From the pointer it picks the first ready unit in increasing index order, wrapping around.
- R7: When no `xu_ready` bit is high, `in_ready` is 0, no `xu_valid` bit is high, and nothing is allocated. The held instruction dispatches unchanged once a unit is ready.
- R8: When the pool is empty, an instruction that needs a destination sees `in_ready`=0. An instruction that needs none still dispatches.
- R9: A `commit_free_valid` pulse naming physical register p (p≠0) returns p to the pool. It can be allocated from the next cycle onward, but not in the cycle of the pulse. A pulse naming 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Block can accept the presented instruction |
| in_seq | input | SEQ_W | Sequence number attached at fetch |
| in_op | input | OP_W | Opaque operation payload |
| in_has_dst | input | 1 | Instruction writes a destination register |
| in_dst_arch | input | 5 | Architectural destination |
| in_src1_arch | input | 5 | Architectural first source |
| in_src2_arch | input | 5 | Architectural second source |
| xu_valid | output | NUM_XU | One-hot instruction valid per execute unit |
| xu_ready | input | NUM_XU | Execute unit can accept this cycle |
| out_seq | output | SEQ_W | Sequence number, unchanged |
| out_op | output | OP_W | Operation payload, unchanged |
| out_has_dst | output | 1 | Destination present flag, unchanged |
| out_dst_arch | output | 5 | Architectural destination, unchanged |
| out_dst_phys | output | $clog2(NUM_PHYS) | Physical destination |
| out_src1_phys | output | $clog2(NUM_PHYS) | Physical first source |
| out_src2_phys | output | $clog2(NUM_PHYS) | Physical second source |
| commit_free_valid | input | 1 | Commit releases a physical register |
| commit_free_phys | input | $clog2(NUM_PHYS) | Physical register being released |

## Verification
Allocation and release can land in the same cycle. The case that matters is a release that arrives while the pool is empty and an instruction that needs a destination is being held. The bench drains the pool and presents such an instruction. In that same cycle it pulses a release of one register. It then checks that `in_ready` stays low in the pulse cycle and that, in the following cycle, the instruction dispatches with exactly the released register as its destination. A release of register 0 into an empty pool is also provoked, and the bench checks that the stall persists.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int ARCH_REGS = 32;
  localparam int ARCH_W    = $clog2(ARCH_REGS);
  typedef logic [ARCH_W-1:0] arch_t;
endpackage

// File: rtl/rd_free_list.sv
module rd_free_list #(
  parameter int NUM_PHYS = 48,
  parameter int PHYS_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_en,
  output logic [PHYS_W-1:0] take_idx,
  output logic              pool_nonempty,
  input  logic              give_en,
  input  logic [PHYS_W-1:0] give_idx
);
  localparam logic [NUM_PHYS-1:0] INIT_POOL = {NUM_PHYS{1'b1}} << rd_pkg::ARCH_REGS;

  logic [NUM_PHYS-1:0] pool_q;
  logic [NUM_PHYS-1:0] pool_d;

  // lowest set bit above 0 wins
  always_comb begin
    pool_nonempty = 1'b0;
    take_idx      = '0;
    for (int i = NUM_PHYS - 1; i >= 1; i--) begin
      if (pool_q[i]) begin
        pool_nonempty = 1'b1;
        take_idx      = PHYS_W'(i);
      end
    end
  end

  always_comb begin
    pool_d = pool_q;
    if (take_en) pool_d[take_idx] = 1'b0;
    if (give_en && (give_idx != '0)) pool_d[give_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pool_q <= INIT_POOL;
    else        pool_q <= pool_d;
  end
endmodule

// File: rtl/rd_rename_table.sv
module rd_rename_table #(
  parameter int PHYS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_pkg::arch_t     look_a,
  input  rd_pkg::arch_t     look_b,
  output logic [PHYS_W-1:0] phys_a,
  output logic [PHYS_W-1:0] phys_b,
  input  logic              upd_en,
  input  rd_pkg::arch_t     upd_arch,
  input  logic [PHYS_W-1:0] upd_phys
);
  localparam int N = rd_pkg::ARCH_REGS;

  logic [PHYS_W-1:0] map_q [N];

  assign phys_a = (look_a == '0) ? '0 : map_q[look_a];
  assign phys_b = (look_b == '0) ? '0 : map_q[look_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) map_q[i] <= PHYS_W'(i);
    end else if (upd_en && (upd_arch != '0)) begin
      map_q[upd_arch] <= upd_phys;
    end
  end
endmodule

// File: rtl/rd_route_arb.sv
module rd_route_arb #(
  parameter int NUM_XU = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want,
  input  logic [NUM_XU-1:0] unit_rdy,
  output logic              some_rdy,
  output logic [NUM_XU-1:0] pick
);
  localparam int PTR_W = (NUM_XU > 1) ? $clog2(NUM_XU) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] win;

  always_comb begin
    some_rdy = 1'b0;
    win      = '0;
    for (int off = NUM_XU - 1; off >= 0; off--) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= NUM_XU) idx = idx - NUM_XU;
      if (unit_rdy[idx]) begin
        some_rdy = 1'b1;
        win      = PTR_W'(idx);
      end
    end
    pick = '0;
    if (want && some_rdy) pick[win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (want && some_rdy)
      ptr_q <= (int'(win) == NUM_XU - 1) ? '0 : win + PTR_W'(1);
  end
endmodule

// File: rtl/rename_dispatch.sv
module rename_dispatch #(
  parameter int NUM_PHYS = 48,
  parameter int NUM_XU   = 3,
  parameter int SEQ_W    = 5,
  parameter int OP_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SEQ_W-1:0]            in_seq,
  input  logic [OP_W-1:0]             in_op,
  input  logic                        in_has_dst,
  input  logic [4:0]                  in_dst_arch,
  input  logic [4:0]                  in_src1_arch,
  input  logic [4:0]                  in_src2_arch,
  output logic [NUM_XU-1:0]           xu_valid,
  input  logic [NUM_XU-1:0]           xu_ready,
  output logic [SEQ_W-1:0]            out_seq,
  output logic [OP_W-1:0]             out_op,
  output logic                        out_has_dst,
  output logic [4:0]                  out_dst_arch,
  output logic [$clog2(NUM_PHYS)-1:0] out_dst_phys,
  output logic [$clog2(NUM_PHYS)-1:0] out_src1_phys,
  output logic [$clog2(NUM_PHYS)-1:0] out_src2_phys,
  input  logic                        commit_free_valid,
  input  logic [$clog2(NUM_PHYS)-1:0] commit_free_phys
);
  localparam int PHYS_W = $clog2(NUM_PHYS);

  logic              needs_reg;
  logic              pool_nonempty;
  logic [PHYS_W-1:0] fresh_reg;
  logic              unit_avail;
  logic              may_go;
  logic              accept;

  assign needs_reg = in_has_dst && (in_dst_arch != '0);
  assign may_go    = !needs_reg || pool_nonempty;
  assign in_ready  = unit_avail && may_go;
  assign accept    = in_valid && in_ready;

  rd_route_arb #(.NUM_XU(NUM_XU)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (in_valid && may_go),
    .unit_rdy (xu_ready),
    .some_rdy (unit_avail),
    .pick     (xu_valid)
  );

  rd_free_list #(.NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W)) pool_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_en       (accept && needs_reg),
    .take_idx      (fresh_reg),
    .pool_nonempty (pool_nonempty),
    .give_en       (commit_free_valid),
    .give_idx      (commit_free_phys)
  );

  rd_rename_table #(.PHYS_W(PHYS_W)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_a   (in_src1_arch),
    .look_b   (in_src2_arch),
    .phys_a   (out_src1_phys),
    .phys_b   (out_src2_phys),
    .upd_en   (accept && needs_reg),
    .upd_arch (in_dst_arch),
    .upd_phys (fresh_reg)
  );

  assign out_dst_phys = needs_reg ? fresh_reg : '0;
  assign out_seq      = in_seq;
  assign out_op       = in_op;
  assign out_has_dst  = in_has_dst;
  assign out_dst_arch = in_dst_arch;
endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
  parameter int NUM_XU = 3,
  parameter int PHYS_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_has_dst,
  input logic [4:0]        in_dst_arch,
  input logic [4:0]        in_src1_arch,
  input logic [NUM_XU-1:0] xu_valid,
  input logic [NUM_XU-1:0] xu_ready,
  input logic [PHYS_W-1:0] out_dst_phys,
  input logic [PHYS_W-1:0] out_src1_phys
);
  logic live_q;
  logic took_q;
  logic [4:0] took_arch_q;
  logic [PHYS_W-1:0] took_phys_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q      <= 1'b0;
      took_q      <= 1'b0;
      took_arch_q <= '0;
      took_phys_q <= '0;
    end else begin
      live_q      <= 1'b1;
      took_q      <= in_valid && in_ready && in_has_dst && (in_dst_arch != '0);
      took_arch_q <= in_dst_arch;
      took_phys_q <= out_dst_phys;
    end
  end

  // R6
  one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xu_valid));
  // R6
  ready_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xu_valid & ~xu_ready) == '0);
  // R6
  accept_routes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ($countones(xu_valid) == 1));
  // R7
  all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xu_ready == '0) |-> (!in_ready && xu_valid == '0));
  // R3
  no_zero_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_has_dst && in_dst_arch != '0) |-> (out_dst_phys != '0));
  // R3
  map_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && took_q && in_src1_arch == took_arch_q) |-> (out_src1_phys == took_phys_q));
  // R2
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_src1_arch == '0) |-> (out_src1_phys == '0));
endmodule

bind rename_dispatch rd_checker #(.NUM_XU(NUM_XU), .PHYS_W($clog2(NUM_PHYS))) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_has_dst    (in_has_dst),
  .in_dst_arch   (in_dst_arch),
  .in_src1_arch  (in_src1_arch),
  .xu_valid      (xu_valid),
  .xu_ready      (xu_ready),
  .out_dst_phys  (out_dst_phys),
  .out_src1_phys (out_src1_phys)
);

// File: tb/rename_dispatch_tb_top.sv
`timescale 1ns/1ps
module rename_dispatch_tb_top;
  localparam int NP = 48;
  localparam int NX = 3;
  localparam int SW = 5;
  localparam int OW = 16;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SW-1:0] in_seq = '0;
  logic [OW-1:0] in_op = '0;
  logic in_has_dst = 1'b0;
  logic [4:0] in_dst_arch = '0, in_src1_arch = '0, in_src2_arch = '0;
  logic [NX-1:0] xu_valid;
  logic [NX-1:0] xu_ready = '0;
  logic [SW-1:0] out_seq;
  logic [OW-1:0] out_op;
  logic out_has_dst;
  logic [4:0] out_dst_arch;
  logic [PW-1:0] out_dst_phys, out_src1_phys, out_src2_phys;
  logic commit_free_valid = 1'b0;
  logic [PW-1:0] commit_free_phys = '0;

  always #2 clk = ~clk;

  rename_dispatch #(.NUM_PHYS(NP), .NUM_XU(NX), .SEQ_W(SW), .OP_W(OW)) dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  map_m [32];
  bit  pool_m [NP];
  int  ptr_m;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 1; i < NP; i++) if (pool_m[i]) return i;
    return 0;
  endfunction

  function automatic int pick_unit(input logic [NX-1:0] r);
    for (int off = 0; off < NX; off++) begin
      int u;
      u = (ptr_m + off) % NX;
      if (r[u]) return u;
    end
    return -1;
  endfunction

  // presents one instruction for one cycle and checks it against the model
  task automatic issue(input string req, input int seq, input bit has, input int dst,
                       input int s1, input int s2, input logic [NX-1:0] rdy);
    int need, fr, u;
    bit go;
    in_valid = 1'b1; in_seq = SW'(seq); in_op = OW'(seq * 37 + 5);
    in_has_dst = has; in_dst_arch = 5'(dst);
    in_src1_arch = 5'(s1); in_src2_arch = 5'(s2); xu_ready = rdy;
    #1;
    need = (has && dst != 0) ? 1 : 0;
    fr   = lowest_free();
    u    = pick_unit(rdy);
    go   = (u >= 0) && (need == 0 || fr != 0);
    chk({req, " in_ready"}, in_ready, go);
    if (go) begin
      chk({req, " R6 xu_valid"}, xu_valid, 1 << u);
      chk({req, " R2 src1"}, out_src1_phys, (s1 == 0) ? 0 : map_m[s1]);
      chk({req, " R2 src2"}, out_src2_phys, (s2 == 0) ? 0 : map_m[s2]);
      chk({req, " R3/R4 dst_phys"}, out_dst_phys, need ? fr : 0);
      chk({req, " R5 fields"}, {out_seq, out_op, out_has_dst, out_dst_arch},
          {in_seq, in_op, in_has_dst, in_dst_arch});
    end else begin
      chk({req, " xu_valid idle"}, xu_valid, 0);
    end
    @(posedge clk);
    if (go) begin
      ptr_m = (u + 1) % NX;
      if (need != 0) begin
        pool_m[fr] = 1'b0;
        map_m[dst] = fr;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) pool_m[i] = (i >= 32);
    ptr_m = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_src1_arch = 5'd7; in_src2_arch = 5'd31; xu_ready = '1;
    #1;
    chk("R1 reset xu_valid", xu_valid, 0);
    chk("R1 reset map r7", out_src1_phys, 7);
    chk("R1 reset map r31", out_src2_phys, 31);
    chk("R1 reset ready", in_ready, 1);
    @(negedge clk);
  endtask

  task automatic t_rename_chain();
    issue("R3 first alloc", 1, 1, 3, 3, 4, '1);
    chk("R1 pool starts at 32", map_m[3], 32);
    issue("R2 src sees old map", 2, 1, 3, 3, 3, '1);
    issue("R3 reads new reg", 3, 1, 9, 3, 0, '1);
  endtask

  task automatic t_zero_dst();
    issue("R4 dst r0", 4, 1, 0, 5, 0, '1);
    issue("R4 no dst", 5, 0, 12, 9, 3, '1);
    issue("R4 pool untouched", 6, 1, 12, 12, 0, '1);
  endtask

  task automatic t_routing();
    issue("R6 rr a", 7, 0, 0, 1, 2, 3'b111);
    issue("R6 rr b", 8, 0, 0, 1, 2, 3'b111);
    issue("R6 only u1", 9, 0, 0, 1, 2, 3'b010);
    issue("R6 skip busy", 10, 0, 0, 1, 2, 3'b011);
  endtask

  task automatic t_all_busy();
    issue("R7 all busy", 11, 1, 20, 3, 9, 3'b000);
    issue("R7 stalled again", 11, 1, 20, 3, 9, 3'b000);
    issue("R7 released", 11, 1, 20, 3, 9, 3'b100);
  endtask

  task automatic t_exhaust_and_free();
    int n = 0;
    while (lowest_free() != 0 && n < NP) begin
      issue("R3 drain", 12 + n, 1, (n % 31) + 1, 0, 0, '1);
      n++;
    end
    issue("R8 empty stall", 20, 1, 14, 1, 2, '1);
    issue("R8 no-dst passes", 21, 0, 14, 1, 2, '1);
    // release of reg 0 must change nothing
    commit_free_valid = 1'b1; commit_free_phys = '0;
    @(negedge clk);
    commit_free_valid = 1'b0;
    issue("R9 free of 0 ignored", 22, 1, 14, 1, 2, '1);
    // release and allocation attempt in the same cycle
    in_valid = 1'b1; in_has_dst = 1'b1; in_dst_arch = 5'd14;
    in_src1_arch = 5'd1; in_src2_arch = 5'd2; xu_ready = '1;
    commit_free_valid = 1'b1; commit_free_phys = PW'(40);
    #1;
    chk("R9 not usable in pulse cycle", in_ready, 0);
    chk("R9 no dispatch in pulse cycle", xu_valid, 0);
    @(posedge clk);
    pool_m[40] = 1'b1;
    @(negedge clk);
    commit_free_valid = 1'b0;
    issue("R9 freed reg reused", 23, 1, 14, 14, 0, '1);
    chk("R9 got released reg", map_m[14], 40);
  endtask

  initial begin
    t_reset();
    t_rename_chain();
    t_zero_dst();
    t_routing();
    t_all_busy();
    t_exhaust_and_free();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule